// File: doc/BRIEF.md
# Two-Level Nesting Interrupt Arbiter

This block sits beside an 8-bit microcontroller core and picks which of six interrupt sources is taken next. Each source offers a request flag. An enable byte masks sources one by one and also carries a master switch. A level byte marks each source as urgent (high) or normal (low). When a request survives masking and may nest over the work already running, the block raises a pending line and presents the 16-bit call target for the core's hardware-generated subroutine call.

The core answers with a one-cycle acknowledge strobe. The block then records the level of the accepted source in one of two in-service flags. A one-cycle return strobe closes the innermost open service. Urgent work can interrupt normal work. Nothing interrupts urgent work, and normal work never interrupts normal work. Among requests of the same level, a fixed scan order decides. Once the pending line rises, the chosen target is frozen until the core acknowledges it.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is held low, and for the two clock cycles after it is released, `irq_o` is 0, `vec_o` is 16'h0000 and `insvc_o` is 2'b00, whatever the inputs are doing.
- R2: Source n (bit n of `req_i`, n = 0..5) can compete only if bit n and bit 7 of `enable_i` are both 1. With bit 7 at 0, every source is masked. Bit 6 of `enable_i` and bit 6 of `level_i` have no effect.
- R3: Among competing sources of the same level, the source with the lowest index wins. The order, from first to last, is: 0 external line A, 1 timer A, 2 external line B, 3 timer B, 4 serial, 5 display busy.
- R4: Bit n of `level_i` equal to 1 makes source n high level. When both levels compete, a high-level source wins over any low-level source, whatever their indices.
- R5: The call targets for sources 0 to 5 are 16'h0003, 16'h000B, 16'h0013, 16'h001B, 16'h002B and 16'h0033.
- R6: With `insvc_o[1]` set, `irq_o` stays 0. With only `insvc_o[0]` set, low-level requests do not raise `irq_o`, but a high-level request does.
- R7: After `irq_o` rises, it stays 1 and `vec_o` stays unchanged until an acknowledge is taken, even if the requests, enables or levels change.
- R8: `ack_i` sampled while `irq_o` is 1 clears `irq_o` on the next cycle. It also sets `insvc_o[1]` if the pending source was high level, or `insvc_o[0]` if it was low level. `ack_i` while `irq_o` is 0 has no effect.
- R9: `reti_i` clears `insvc_o[1]` if it is set, and otherwise clears `insvc_o[0]`.
- R10: A qualifying request sampled at a rising edge when nothing is pending shows up on `irq_o` and `vec_o` right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 6 | Request flags, one per source, in scan order |
| enable_i | input | 8 | Bits 0..5: per-source enables. Bit 7: master enable |
| level_i | input | 8 | Bits 0..5: 1 means high level, 0 means low level |
| ack_i | input | 1 | Core takes the pending interrupt (one-cycle strobe) |
| reti_i | input | 1 | Core returns from the innermost service routine (one-cycle strobe) |
| irq_o | output | 1 | An interrupt is pending for the core |
| vec_o | output | 16 | Call target of the pending source |
| insvc_o | output | 2 | In-service flags: bit 1 high level, bit 0 low level |

## Verification
The sweep goes through all 64 request patterns under several enable and level bytes. Some of these bytes set bit 6, and some clear the master bit. A design with a wrong mask would let a disabled source win. A design with an inverted scan would report the last source instead of the first. A design that ranks by index and ignores level would let a low source beat a high one.

Directed sequences cover nesting. A high request is taken over low work. Low and high requests are then both refused once high work is open. Returns then unwind in the right order: a design that clears the wrong flag leaves the low service stuck open.

A freeze test changes the requests after pending is raised, to catch a design that re-arbitrates and changes the target under the core. The same test checks that the frozen low-level pick opens the low service, not the high one. A stray acknowledge with nothing pending must leave the flags alone.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  localparam int NSRC   = 6;
  localparam int IDXW   = $clog2(NSRC);
  localparam int VECW   = 16;
  localparam int REGW   = 8;
  localparam int GEN_BIT = REGW - 1;
  localparam int NLVL   = 2;

  typedef enum logic [0:0] {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } lvl_e;

  typedef struct packed {
    logic            found;
    logic [IDXW-1:0] idx;
  } pick_t;

  // Slots are 8 bytes apart starting at 3; slot 4 (offset 0x23) is skipped.
  function automatic logic [VECW-1:0] vec_of(input logic [IDXW-1:0] idx);
    logic [VECW-1:0] v;
    v = (VECW'(idx) << 3) + VECW'(3);
    if (idx >= IDXW'(4)) v = v + VECW'(8);
    return v;
  endfunction

endpackage

// File: rtl/prio_irq_mask.sv
module prio_irq_mask
  import prio_irq_pkg::*;
(
  input  logic [NSRC-1:0] req_i,
  input  logic [REGW-1:0] enable_i,
  input  logic [REGW-1:0] level_i,
  output logic [NSRC-1:0] hi_req_o,
  output logic [NSRC-1:0] lo_req_o
);

  logic [NSRC-1:0] qual;

  always_comb begin
    qual     = req_i & enable_i[NSRC-1:0] & {NSRC{enable_i[GEN_BIT]}};
    hi_req_o = qual &  level_i[NSRC-1:0];
    lo_req_o = qual & ~level_i[NSRC-1:0];
  end

endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick
  import prio_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] req_i,
  output pick_t        pick_o
);

  // Scan from the last index down so the lowest set index wins.
  always_comb begin
    pick_o.found = 1'b0;
    pick_o.idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        pick_o.found = 1'b1;
        pick_o.idx   = IDXW'(i);
      end
    end
  end

endmodule

// File: rtl/prio_irq_insvc.sv
module prio_irq_insvc
  import prio_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en_i,
  input  lvl_e            set_lvl_i,
  input  logic            reti_i,
  output logic [NLVL-1:0] insvc_o
);

  logic [NLVL-1:0] insvc_q;
  logic [NLVL-1:0] insvc_d;
  logic            insvc_en;

  always_comb begin
    insvc_d = insvc_q;
    // Return closes the innermost open level first.
    if (reti_i) begin
      if (insvc_q[LVL_HI]) insvc_d[LVL_HI] = 1'b0;
      else                 insvc_d[LVL_LO] = 1'b0;
    end
    if (set_en_i) insvc_d[set_lvl_i] = 1'b1;
    insvc_en = reti_i | set_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        insvc_q <= '0;
    else if (insvc_en) insvc_q <= insvc_d;
  end

  assign insvc_o = insvc_q;

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [REGW-1:0] enable_i,
  input  logic [REGW-1:0] level_i,
  input  logic            ack_i,
  input  logic            reti_i,
  output logic            irq_o,
  output logic [VECW-1:0] vec_o,
  output logic [NLVL-1:0] insvc_o
);

  // Reset synchronizer: asserts at once, releases on the second edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Masking and per-level split.
  logic [NSRC-1:0] lvl_req [NLVL];
  pick_t           lvl_pick [NLVL];

  prio_irq_mask u_mask (
    .req_i    (req_i),
    .enable_i (enable_i),
    .level_i  (level_i),
    .hi_req_o (lvl_req[LVL_HI]),
    .lo_req_o (lvl_req[LVL_LO])
  );

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    prio_irq_pick #(.N(NSRC)) u_pick (
      .req_i  (lvl_req[g]),
      .pick_o (lvl_pick[g])
    );
  end

  // Pending state.
  logic            pend_q, pend_d;
  lvl_e            lvl_q, lvl_d;
  logic [VECW-1:0] vec_q, vec_d;
  logic            pend_en;
  logic            take;
  logic [NLVL-1:0] insvc;

  prio_irq_insvc u_insvc (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .set_en_i  (take),
    .set_lvl_i (lvl_q),
    .reti_i    (reti_i),
    .insvc_o   (insvc)
  );

  always_comb begin
    take    = pend_q & ack_i;
    pend_d  = pend_q;
    lvl_d   = lvl_q;
    vec_d   = vec_q;
    pend_en = 1'b0;
    if (pend_q) begin
      // Frozen until taken.
      if (ack_i) begin
        pend_d  = 1'b0;
        pend_en = 1'b1;
      end
    end else if (lvl_pick[LVL_HI].found && !insvc[LVL_HI]) begin
      pend_d  = 1'b1;
      lvl_d   = LVL_HI;
      vec_d   = vec_of(lvl_pick[LVL_HI].idx);
      pend_en = 1'b1;
    end else if (lvl_pick[LVL_LO].found && (insvc == '0)) begin
      pend_d  = 1'b1;
      lvl_d   = LVL_LO;
      vec_d   = vec_of(lvl_pick[LVL_LO].idx);
      pend_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pend_q <= 1'b0;
      lvl_q  <= LVL_LO;
      vec_q  <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
      lvl_q  <= lvl_d;
      vec_q  <= vec_d;
    end
  end

  assign irq_o   = pend_q;
  assign vec_o   = vec_q;
  assign insvc_o = insvc;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [REGW-1:0] enable_i,
  input logic            ack_i,
  input logic            reti_i,
  input logic            irq_o,
  input logic [VECW-1:0] vec_o,
  input logic [NLVL-1:0] insvc_o
);

  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_i) |=> (irq_o && $stable(vec_o)));

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_i) |=> (!irq_o && (insvc_o != 2'b00)));

  a_r6_no_nest_over_high: assert property (@(posedge clk) disable iff (!rst_n)
    insvc_o[1] |-> !irq_o);

  a_r2_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i[GEN_BIT] && !irq_o) |=> !irq_o);

  a_r9_reti_high_first: assert property (@(posedge clk) disable iff (!rst_n)
    (insvc_o[1] && reti_i && !ack_i) |=> !insvc_o[1]);

  a_r5_vector_set: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_o == 16'h0003 || vec_o == 16'h000B || vec_o == 16'h0013 ||
               vec_o == 16'h001B || vec_o == 16'h002B || vec_o == 16'h0033));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable_i (enable_i),
  .ack_i    (ack_i),
  .reti_i   (reti_i),
  .irq_o    (irq_o),
  .vec_o    (vec_o),
  .insvc_o  (insvc_o)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;

  logic        clk;
  logic        rst_n;
  logic [5:0]  req_i;
  logic [7:0]  enable_i;
  logic [7:0]  level_i;
  logic        ack_i;
  logic        reti_i;
  logic        irq_o;
  logic [15:0] vec_o;
  logic [1:0]  insvc_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  prio_irq_ctrl u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .enable_i (enable_i),
    .level_i  (level_i),
    .ack_i    (ack_i),
    .reti_i   (reti_i),
    .irq_o    (irq_o),
    .vec_o    (vec_o),
    .insvc_o  (insvc_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string rid, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rid, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(input int idx);
    case (idx)
      0: return 16'h0003;
      1: return 16'h000B;
      2: return 16'h0013;
      3: return 16'h001B;
      4: return 16'h002B;
      default: return 16'h0033;
    endcase
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  // One request pattern from idle: pick, take, return.
  task automatic sweep_case(input logic [5:0] rq, input logic [7:0] en, input logic [7:0] pr);
    logic [5:0] q, hi, lo;
    int  idx;
    bit  found;
    bit  is_hi;
    q  = rq & en[5:0] & {6{en[7]}};
    hi = q & pr[5:0];
    lo = q & ~pr[5:0];
    found = 0; idx = 0; is_hi = 0;
    if (hi != 0) begin
      found = 1; is_hi = 1;
      for (int i = 5; i >= 0; i--) if (hi[i]) idx = i;
    end else if (lo != 0) begin
      found = 1;
      for (int i = 5; i >= 0; i--) if (lo[i]) idx = i;
    end
    req_i = rq; enable_i = en; level_i = pr;
    tick();
    check("R10/R2 pending", {31'd0, irq_o}, {31'd0, found});
    if (found) check("R3/R4/R5 vector", {16'd0, vec_o}, {16'd0, exp_vec(idx)});
    req_i = '0;
    ack_i = found;
    tick();
    ack_i = 1'b0;
    if (found) begin
      check("R8 irq cleared", {31'd0, irq_o}, 32'd0);
      check("R8 level flag", {30'd0, insvc_o}, is_hi ? 32'd2 : 32'd1);
      reti_i = 1'b1;
      tick();
      reti_i = 1'b0;
      check("R9 unwind", {30'd0, insvc_o}, 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] en_set [6];
    logic [7:0] pr_set [5];
    en_set = '{8'hBF, 8'hFF, 8'h3F, 8'hA5, 8'hDA, 8'hC0};
    pr_set = '{8'h00, 8'h3F, 8'h15, 8'h6A, 8'h0F};

    rst_n = 1'b0; req_i = 6'h3F; enable_i = 8'hFF; level_i = 8'h00;
    ack_i = 1'b0; reti_i = 1'b0;
    repeat (3) tick();
    // R1: outputs idle under reset with requests active
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    check("R1 vec", {16'd0, vec_o}, 32'd0);
    check("R1 insvc", {30'd0, insvc_o}, 32'd0);
    req_i = '0;
    rst_n = 1'b1;
    tick();
    check("R1 irq after release", {31'd0, irq_o}, 32'd0);
    repeat (2) tick();

    // R8: acknowledge with nothing pending is ignored
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    check("R8 stray ack", {30'd0, insvc_o}, 32'd0);

    for (int e = 0; e < 6; e++)
      for (int p = 0; p < 5; p++)
        for (int r = 0; r < 64; r++)
          sweep_case(6'(r), en_set[e], pr_set[p]);

    // R6/R9 nesting sequence
    enable_i = 8'hFF; level_i = 8'h00; req_i = 6'b000100;
    tick();
    check("R6 low start", {16'd0, vec_o}, 32'h0013);
    ack_i = 1'b1; req_i = '0; tick(); ack_i = 1'b0;
    check("R6 low open", {30'd0, insvc_o}, 32'd1);
    req_i = 6'b000001; tick(); tick();
    check("R6 low blocked by low", {31'd0, irq_o}, 32'd0);
    level_i = 8'h02; req_i = 6'b000011; tick();
    check("R6 high over low", {31'd0, irq_o}, 32'd1);
    check("R6 high vector", {16'd0, vec_o}, 32'h000B);
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    check("R6 both open", {30'd0, insvc_o}, 32'd3);
    tick(); tick();
    check("R6 high blocks all", {31'd0, irq_o}, 32'd0);
    req_i = '0; reti_i = 1'b1; tick(); reti_i = 1'b0;
    check("R9 high closed first", {30'd0, insvc_o}, 32'd1);
    reti_i = 1'b1; tick(); reti_i = 1'b0;
    check("R9 low closed", {30'd0, insvc_o}, 32'd0);

    // R7 freeze after pending rises
    level_i = 8'h00; req_i = 6'b100000; tick();
    check("R7 initial vector", {16'd0, vec_o}, 32'h0033);
    level_i = 8'h01; req_i = 6'b000001;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R7 irq held", {31'd0, irq_o}, 32'd1);
      check("R7 vector held", {16'd0, vec_o}, 32'h0033);
    end
    req_i = '0; ack_i = 1'b1; tick(); ack_i = 1'b0;
    check("R7/R8 frozen level is low", {30'd0, insvc_o}, 32'd1);
    reti_i = 1'b1; tick(); reti_i = 1'b0;
    check("R9 closed", {30'd0, insvc_o}, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule